// File: doc/BRIEF.md
# Pipelined Wide Modular Adder-Subtractor

This block adds or subtracts two wide field elements with one new operation accepted on every clock. The operand is cut into fixed-width chunks (256 bits by default). Each chunk is handled by its own slice, one pipeline stage after the slice below it. The carry or borrow moves up one stage per cycle. Lower chunks are held back so that every chunk of a result leaves in the same cycle. The latency is the chunk count, so a 504-bit datapath (a 503-bit modulus plus one headroom bit for 2p) takes two cycles.

The first operand is picked from either input word. The second operand is picked from the second input word, the modulus p, twice the modulus, or zero. This lets one datapath do plain field addition and subtraction, as well as conditional reductions such as "subtract p, and add it back if the result went negative". When a subtraction borrows, the result has the chosen modulus multiple (p or 2p) added back. This keeps operands in the redundant range [0, 2p) within one pass. The corrected difference is computed alongside the plain one, so the correction adds no extra cycle.

Top module: `modadd_pipe`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `out_res` is 0.
- R2: Every cycle with `in_valid` high produces exactly one cycle of `out_valid`, exactly NCH = ceil(DATA_W / CHUNK_W) cycles later (2 with the defaults). Operations may be issued on consecutive cycles.
- R3: `a_sel` = 0 takes the first operand from `a_in`, and `a_sel` = 1 takes it from `b_in`.
- R4: `b_sel` picks the second operand with the encoding 0 = `b_in`, 1 = p, 2 = 2p, 3 = zero.
- R5: With `sub` = 0, the result is (op1 + op2) mod 2^DATA_W, with no correction applied.
- R6: With `sub` = 1 and op1 >= op2, the result is op1 - op2.
- R7: With `sub` = 1 and op1 < op2, the result is (op1 - op2 + K) mod 2^DATA_W. K is p when `fix_2p` = 0 and 2p when `fix_2p` = 1.
- R8: In a cycle where no result leaves, `out_res` keeps its previous value, whatever is on the inputs.
- R9: A carry or borrow crossing a chunk boundary reaches the upper chunk correctly, for example (2^256 - 1) + 1 and 2^256 - 1.
- R10: Subtracting an operand from itself, or adding zero to zero, gives 0.
- R11: The operation select and the correction select travel with their own operands, so interleaved additions and subtractions in consecutive cycles each give their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| sub | input | 1 | 1 = subtract, 0 = add |
| a_sel | input | 1 | First operand source: 0 `a_in`, 1 `b_in` |
| b_sel | input | 2 | Second operand source: 0 `b_in`, 1 p, 2 2p, 3 zero |
| fix_2p | input | 1 | Borrow correction multiple: 0 p, 1 2p |
| a_in | input | DATA_W | First input word |
| b_in | input | DATA_W | Second input word |
| out_valid | output | 1 | Result valid |
| out_res | output | DATA_W | Registered result |

## Verification
If a chunk carry is lost or stored in the wrong stage, the result of the same operation is off by an exact multiple of 2^256, and no earlier or later result is affected. Directed cross-boundary cases expose this as soon as that result appears. If a flag or operand skew register is misaligned, the damage shows one operation later: a result mixes the add/sub or correction choice of its neighbour. Back-to-back streams of interleaved operations catch this within NCH cycles of the first mixed pair. A wrong valid delay shows at once as a result that arrives early, late, or not at all, measured against the cycle it was issued.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

  // Second-operand source encoding (b_sel)
  typedef enum logic [1:0] {
    OP2_PORT = 2'd0,
    OP2_P    = 2'd1,
    OP2_2P   = 2'd2,
    OP2_ZERO = 2'd3
  } op2_src_e;

  function automatic int chunk_count(input int width, input int chunk);
    return (width + chunk - 1) / chunk;
  endfunction

endpackage

// File: rtl/modadd_delay.sv
// Plain shift delay with no reset, so it can map to shift-register primitives.
module modadd_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < DEPTH; i++) begin
      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/modadd_lane.sv
// One lower chunk slice. It computes the plain sum/difference (lane 0) and the
// difference plus the correction multiple (lane 1), registers both together with
// their carries, then holds the results back until the top chunk is ready.
module modadd_lane #(
  parameter int          SW  = 256,
  parameter int          IDX = 0,
  parameter int          NCH = 2,
  parameter logic [SW-1:0] KP  = '0,
  parameter logic [SW-1:0] K2P = '0
) (
  input  logic          clk,
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          sub,
  input  logic          fix2,
  input  logic          c0_in,
  input  logic [1:0]    c1_in,
  output logic          c0_out,
  output logic [1:0]    c1_out,
  output logic [SW-1:0] r0_out,
  output logic [SW-1:0] r1_out
);

  localparam int BUNDLE_W = 2 * SW + 2;
  localparam int DESKEW   = NCH - 2 - IDX;

  logic [BUNDLE_W-1:0] bund_in, bund_sk;
  logic [SW-1:0]       x_d, y_d, yy, kk;
  logic                sub_d, fix_d;
  logic [SW:0]         s0;
  logic [SW+1:0]       s1;
  logic [SW-1:0]       r0_q, r1_q;

  assign bund_in = {sub, fix2, x, y};

  generate
    if (IDX == 0) begin : g_noskew
      assign bund_sk = bund_in;
    end else begin : g_skew
      modadd_delay #(.W(BUNDLE_W), .DEPTH(IDX)) u_skew (
        .clk (clk),
        .d   (bund_in),
        .q   (bund_sk)
      );
    end
  endgenerate

  assign sub_d = bund_sk[BUNDLE_W-1];
  assign fix_d = bund_sk[BUNDLE_W-2];
  assign x_d   = bund_sk[2*SW-1:SW];
  assign y_d   = bund_sk[SW-1:0];

  always_comb begin
    yy = sub_d ? ~y_d : y_d;
    kk = fix_d ? K2P : KP;
    s0 = {1'b0, x_d} + {1'b0, yy} + {{SW{1'b0}}, c0_in};
    s1 = {2'b00, x_d} + {2'b00, kk} + {2'b00, ~y_d} + {{SW{1'b0}}, c1_in};
  end

  always_ff @(posedge clk) begin
    c0_out <= s0[SW];
    c1_out <= s1[SW+1:SW];
    r0_q   <= s0[SW-1:0];
    r1_q   <= s1[SW-1:0];
  end

  generate
    if (DESKEW == 0) begin : g_nodeskew
      assign r0_out = r0_q;
      assign r1_out = r1_q;
    end else begin : g_deskew
      modadd_delay #(.W(2 * SW), .DEPTH(DESKEW)) u_deskew (
        .clk (clk),
        .d   ({r0_q, r1_q}),
        .q   ({r0_out, r1_out})
      );
    end
  endgenerate

endmodule

// File: rtl/modadd_head.sv
// Top chunk slice. It finishes both lanes combinationally and decides the final
// borrow, which picks the lane for every chunk at the output register.
module modadd_head #(
  parameter int            SW  = 248,
  parameter int            IDX = 1,
  parameter logic [SW-1:0] KP  = '0,
  parameter logic [SW-1:0] K2P = '0
) (
  input  logic          clk,
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          sub,
  input  logic          fix2,
  input  logic          c0_in,
  input  logic [1:0]    c1_in,
  output logic [SW-1:0] res_out,
  output logic          brw_out
);

  localparam int BUNDLE_W = 2 * SW + 2;

  logic [BUNDLE_W-1:0] bund_in, bund_sk;
  logic [SW-1:0]       x_d, y_d, yy, kk, r1;
  logic                sub_d, fix_d;
  logic [SW:0]         s0;

  assign bund_in = {sub, fix2, x, y};

  generate
    if (IDX == 0) begin : g_noskew
      assign bund_sk = bund_in;
    end else begin : g_skew
      modadd_delay #(.W(BUNDLE_W), .DEPTH(IDX)) u_skew (
        .clk (clk),
        .d   (bund_in),
        .q   (bund_sk)
      );
    end
  endgenerate

  assign sub_d = bund_sk[BUNDLE_W-1];
  assign fix_d = bund_sk[BUNDLE_W-2];
  assign x_d   = bund_sk[2*SW-1:SW];
  assign y_d   = bund_sk[SW-1:0];

  always_comb begin
    yy      = sub_d ? ~y_d : y_d;
    kk      = fix_d ? K2P : KP;
    s0      = {1'b0, x_d} + {1'b0, yy} + {{SW{1'b0}}, c0_in};
    r1      = x_d + kk + ~y_d + SW'(c1_in);
    brw_out = sub_d & ~s0[SW];
    res_out = brw_out ? r1 : s0[SW-1:0];
  end

endmodule

// File: rtl/modadd_pipe.sv
module modadd_pipe
  import modadd_pkg::*;
#(
  parameter int                DATA_W  = 504,
  parameter int                CHUNK_W = 256,
  parameter logic [DATA_W-1:0] MOD_P   = (DATA_W'(1) << (DATA_W - 1))
                                         - (DATA_W'(1) << 260) - DATA_W'(19)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              sub,
  input  logic              a_sel,
  input  logic [1:0]        b_sel,
  input  logic              fix_2p,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res
);

  localparam int                NCH    = chunk_count(DATA_W, CHUNK_W);
  localparam int                LAST_W = DATA_W - (NCH - 1) * CHUNK_W;
  localparam int                LOW_W  = (NCH > 1) ? (NCH - 1) * CHUNK_W : 1;
  localparam logic [DATA_W-1:0] MOD_2P = {MOD_P[DATA_W-2:0], 1'b0};

  logic [DATA_W-1:0]    op1, op2, res_next;
  logic [NCH-1:0]       c0v;
  logic [NCH-1:0][1:0]  c1v;
  logic [LOW_W-1:0]     lo0, lo1;
  logic [LAST_W-1:0]    hi_res;
  logic                 brw;
  logic                 v_head;

  // Operand source selection
  always_comb begin
    op1 = a_sel ? b_in : a_in;
    unique case (op2_src_e'(b_sel))
      OP2_PORT: op2 = b_in;
      OP2_P:    op2 = MOD_P;
      OP2_2P:   op2 = MOD_2P;
      default:  op2 = '0;
    endcase
  end

  // Carry-in of chunk 0: +1 completes the two's complement in both lanes
  assign c0v[0] = sub;
  assign c1v[0] = 2'd1;

  generate
    for (genvar j = 0; j < NCH - 1; j++) begin : g_lane
      modadd_lane #(
        .SW  (CHUNK_W),
        .IDX (j),
        .NCH (NCH),
        .KP  (MOD_P[j*CHUNK_W +: CHUNK_W]),
        .K2P (MOD_2P[j*CHUNK_W +: CHUNK_W])
      ) u_lane (
        .clk    (clk),
        .x      (op1[j*CHUNK_W +: CHUNK_W]),
        .y      (op2[j*CHUNK_W +: CHUNK_W]),
        .sub    (sub),
        .fix2   (fix_2p),
        .c0_in  (c0v[j]),
        .c1_in  (c1v[j]),
        .c0_out (c0v[j+1]),
        .c1_out (c1v[j+1]),
        .r0_out (lo0[j*CHUNK_W +: CHUNK_W]),
        .r1_out (lo1[j*CHUNK_W +: CHUNK_W])
      );
    end

    if (NCH == 1) begin : g_single
      assign lo0 = '0;
      assign lo1 = '0;
    end
  endgenerate

  modadd_head #(
    .SW  (LAST_W),
    .IDX (NCH - 1),
    .KP  (MOD_P[DATA_W-1 -: LAST_W]),
    .K2P (MOD_2P[DATA_W-1 -: LAST_W])
  ) u_head (
    .clk     (clk),
    .x       (op1[DATA_W-1 -: LAST_W]),
    .y       (op2[DATA_W-1 -: LAST_W]),
    .sub     (sub),
    .fix2    (fix_2p),
    .c0_in   (c0v[NCH-1]),
    .c1_in   (c1v[NCH-1]),
    .res_out (hi_res),
    .brw_out (brw)
  );

  // Valid travels alongside the data skew
  generate
    if (NCH == 1) begin : g_vdirect
      assign v_head = in_valid;
      assign res_next = hi_res;
    end else begin : g_vpipe
      logic [NCH-2:0] vpipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          vpipe <= '0;
        end else begin
          vpipe <= (vpipe << 1) | (NCH-1)'(in_valid);
        end
      end
      assign v_head   = vpipe[NCH-2];
      assign res_next = {hi_res, (brw ? lo1 : lo0)};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= v_head;
      if (v_head) begin
        out_res <= res_next;
      end
    end
  end

endmodule

// File: rtl/modadd_pipe_chk.sv
module modadd_pipe_chk #(
  parameter int DATA_W = 504,
  parameter int NCH    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              sub,
  input logic              a_sel,
  input logic [1:0]        b_sel,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_res
);

  logic [NCH-1:0] issue_q;
  logic [NCH-1:0] zero_q;
  logic           zero_op;

  // Operations whose result must be zero: x - x, or 0 + 0
  assign zero_op = in_valid && !a_sel &&
                   ((sub && b_sel == 2'd0 && a_in == b_in) ||
                    (!sub && b_sel == 2'd3 && a_in == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q <= '0;
      zero_q  <= '0;
    end else begin
      issue_q <= (issue_q << 1) | NCH'(in_valid);
      zero_q  <= (zero_q << 1) | NCH'(zero_op);
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_res == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == issue_q[NCH-1]);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_res));

  // R10
  self_zero_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q[NCH-1] |-> (out_valid && out_res == '0));

endmodule

bind modadd_pipe modadd_pipe_chk #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sub       (sub),
  .a_sel     (a_sel),
  .b_sel     (b_sel),
  .a_in      (a_in),
  .b_in      (b_in),
  .out_valid (out_valid),
  .out_res   (out_res)
);

// File: tb/modadd_pipe_tb_top.sv
module modadd_pipe_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          W          = 504;
  localparam int          CW         = 256;
  localparam int          LAT        = (W + CW - 1) / CW;
  localparam int          WDOG       = 20000;
  localparam logic [W-1:0] P  = (W'(1) << 503) - (W'(1) << 260) - W'(19);
  localparam logic [W-1:0] P2 = P << 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         sub = 1'b0;
  logic         a_sel = 1'b0;
  logic [1:0]   b_sel = 2'd0;
  logic         fix_2p = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         out_valid;
  logic [W-1:0] out_res;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit finished = 0;
  logic [W-1:0] last_res = '0;

  logic [W-1:0] exp_q[$];
  int           due_q[$];
  string        tag_q[$];

  modadd_pipe #(.DATA_W(W), .CHUNK_W(CW), .MOD_P(P)) dut_i (
    .clk, .rst, .in_valid, .sub, .a_sel, .b_sel, .fix_2p,
    .a_in, .b_in, .out_valid, .out_res
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic asel, input logic [1:0] bsel, input logic sb, input logic fx);
    logic [W-1:0] x, y, k;
    x = asel ? b : a;
    case (bsel)
      2'd0:    y = b;
      2'd1:    y = P;
      2'd2:    y = P2;
      default: y = '0;
    endcase
    k = fx ? P2 : P;
    if (!sb) return x + y;
    if (x >= y) return x - y;
    return x - y + k;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] v = '0;
    for (int i = 0; i < 16; i++) v = (v << 32) | W'($urandom);
    return v;
  endfunction

  // Output monitor: compares data and arrival cycle of every result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", W'(1), W'(0));
      end else begin
        logic [W-1:0] e;
        int           d;
        string        t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        check(out_res == e, t, out_res, e);
        check(cyc == d, "R2 latency", W'(cyc), W'(d));
        last_res = out_res;
      end
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic asel,
                       input logic [1:0] bsel, input logic sb, input logic fx,
                       input string tag);
    in_valid = 1'b1; a_in = a; b_in = b; a_sel = asel; b_sel = bsel;
    sub = sb; fix_2p = fx;
    exp_q.push_back(ref_model(a, b, asel, bsel, sb, fx));
    due_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    for (int i = 0; i < LAT + 4 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R2 missing result", W'(exp_q.size()), W'(0));
  endtask

  task automatic t_reset();
    // R1: cleared outputs right after reset
    check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), W'(0));
    check(out_res == '0, "R1 out_res", out_res, '0);
  endtask

  task automatic t_add();
    issue(W'(5), W'(7), 0, 2'd0, 0, 0, "R5 small add");
    issue(P - 1, W'(1), 0, 2'd0, 0, 0, "R5 p-1 plus 1");
    issue(P2 - 1, P2 - 1, 0, 2'd0, 0, 1, "R5 wrap mod 2^W");
    issue('0, '0, 0, 2'd0, 0, 0, "R5 zero add");
    drain();
  endtask

  task automatic t_sources();
    issue(W'(3), W'(100), 1, 2'd0, 0, 0, "R3 a_sel picks b_in");
    issue(W'(9), W'(100), 1, 2'd3, 1, 0, "R3 b_in minus zero");
    issue(W'(11), W'(2), 0, 2'd1, 0, 0, "R4 plus p");
    issue(W'(11), W'(2), 0, 2'd2, 0, 0, "R4 plus 2p");
    issue(W'(11), W'(2), 0, 2'd3, 0, 0, "R4 plus zero");
    drain();
  endtask

  task automatic t_sub();
    issue(P - 1, W'(1), 0, 2'd0, 1, 0, "R6 p-1 minus 1");
    issue(P2 - 1, P, 0, 2'd1, 1, 0, "R6 reduce by p");
    issue(W'(1), W'(2), 0, 2'd0, 1, 0, "R7 borrow plus p");
    issue(W'(1), W'(2), 0, 2'd0, 1, 1, "R7 borrow plus 2p");
    issue(P - 1, P, 0, 2'd1, 1, 0, "R7 conditional reduce keeps value");
    issue('0, P - 1, 0, 2'd0, 1, 1, "R7 zero minus p-1");
    drain();
  endtask

  task automatic t_chunk();
    logic [W-1:0] lo_ones;
    lo_ones = (W'(1) << 256) - W'(1);
    issue(lo_ones, W'(1), 0, 2'd0, 0, 0, "R9 carry into chunk 1");
    issue(W'(1) << 256, W'(1), 0, 2'd0, 1, 0, "R9 borrow from chunk 1");
    issue(W'(1) << 256, lo_ones << 1, 0, 2'd0, 1, 1, "R9 cross borrow corrected");
    drain();
  endtask

  task automatic t_zero();
    issue(P - 1, P - 1, 0, 2'd0, 1, 0, "R10 self subtract");
    issue('0, W'(77), 0, 2'd3, 0, 1, "R10 zero plus zero");
    drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 48; i++) begin
      logic [W-1:0] a, b;
      a = rnd_word() % P2;
      b = rnd_word() % P2;
      if (i % 7 == 0) a = '0;
      if (i % 5 == 0) b = P - 1;
      issue(a, b, 1'($urandom), 2'($urandom), 1'(i % 2), 1'($urandom), "R11 interleaved stream");
    end
    drain();
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    held = last_res;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b0; a_in = rnd_word(); b_in = rnd_word();
      sub = 1'($urandom); b_sel = 2'($urandom); a_sel = 1'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 no valid while idle", W'(out_valid), W'(0));
      check(out_res == held, "R8 result held", out_res, held);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sources();
    t_sub();
    t_chunk();
    t_zero();
    t_stream();
    t_hold();
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected < %0d", WDOG, WDOG);
      finish_run();
    end
  end

endmodule